// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Transfer Strobe

This block takes a five-digit BCD conversion result and shows it one digit at a time. Each digit gets a window on a shared 4-bit BCD bus and a one-hot digit-drive line. When the conversion controller pulses its end-of-cycle input, the block captures the digits and the overrange flag. It then walks the digit windows from the most significant digit down to the least significant. The most significant window is one clock longer than the others.

In each window of that first walk, an active-low transfer strobe is issued halfway through. External latches, a serial transmitter or a processor can capture the digit on that strobe. The strobe is low only during the low half of a single clock cycle. After the fifth strobe the block keeps scanning the same digits for a display, with no further strobes, until the next end-of-cycle pulse. While the captured overrange flag is set, the digit drives blink.

The result input is not a stream. The controller presents the digits as plain levels and marks them with a single-cycle capture pulse. There is no back-pressure: a capture pulse is always taken at once, and the block never stalls the controller.

Top module: `mdisp_scan`

## Requirements
- R1: After reset, and until the first capture pulse, all digit drives are low, the BCD bus is 0 and the strobe is high.
- R2: A capture pulse (`cycle_end_i` high at a rising edge) latches `digits_i` and `ovr_i`. From the next cycle, `dig_o[4]` (most significant digit) is active for 201 cycles.
- R3: After the most significant window, `dig_o[3]`, `dig_o[2]`, `dig_o[1]` and `dig_o[0]` are each active for 200 cycles, in that order. At most one digit drive is high at any time.
- R4: In each window of the strobed walk, `strobe_n_o` is low only during the low half of the cycle that lies 100 cycles after the window opened (the window's 101st cycle).
- R5: Each capture pulse yields exactly five strobe pulses. After that, the 1001-cycle frame repeats from the most significant digit with no strobes.
- R6: `bcd_o` carries `digits_i[4*i+3:4*i]` of the latched value for the active digit i. Bit 0 has weight 1 and bit 3 has weight 8. The bus changes only where a window opens.
- R7: When the latched overrange flag is set, all digit drives are low while (cycles since the capture / BLINK_CYC) is odd, using integer division. `bcd_o` and the strobes are not affected.
- R8: A capture pulse in the middle of a walk restarts it from the most significant digit with the new digits and five new strobes. Changes on `digits_i` or `ovr_i` without a capture pulse have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_end_i | input | 1 | Single-cycle capture pulse at the end of a conversion |
| digits_i | input | 20 | Five BCD digits; digit i occupies bits 4*i+3:4*i |
| ovr_i | input | 1 | Overrange flag, captured with the digits |
| bcd_o | output | 4 | Multiplexed BCD digit value |
| dig_o | output | 5 | One-hot digit drives; bit 4 is the most significant digit |
| strobe_n_o | output | 1 | Active-low transfer strobe, half a clock wide |

## Verification
The assertions check the following on every cycle:
- At most one digit drive is high.
- The walk starts at the most significant digit right after a capture.
- The BCD bus holds steady inside a window.
- Each strobe lasts a single cycle, and a walk never produces more than five.
- The block stays quiet before the first capture.

The exact window lengths, the strobe's position and its half-cycle width, the blink cadence, and the fact that unlatched input changes are ignored only show up through the bench's scenarios. There, a cycle-counting reference model is compared against the outputs on every clock. Those scenarios include a plain capture, an overrange capture and a restart in the middle of a walk.

// File: rtl/mdisp_pkg.sv
`timescale 1ns/1ps
package mdisp_pkg;
  typedef enum logic {PH_SHOW = 1'b0, PH_BLANK = 1'b1} blink_ph_e;
endpackage

// File: rtl/mdisp_timer.sv
`timescale 1ns/1ps
module mdisp_timer #(
  parameter int NDIG    = 5,
  parameter int MSD_LEN = 201,
  parameter int DIG_LEN = 200,
  parameter int STB_POS = 100,
  localparam int CW = $clog2(MSD_LEN + 1),
  localparam int SW = $clog2(NDIG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  output logic          active_o,
  output logic [SW-1:0] slot_o,
  output logic [CW-1:0] cnt_o,
  output logic          stb_o
);
  localparam logic [SW-1:0] TOP_SLOT = SW'(NDIG - 1);
  localparam logic [CW-1:0] MSD_LAST = CW'(MSD_LEN - 1);
  localparam logic [CW-1:0] DIG_LAST = CW'(DIG_LEN - 1);
  localparam logic [CW-1:0] STB_AT   = CW'(STB_POS);

  logic          active_q, strobing_q;
  logic [SW-1:0] slot_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = (slot_q == TOP_SLOT) ? MSD_LAST : DIG_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      strobing_q <= 1'b0;
      slot_q     <= '0;
      cnt_q      <= '0;
    end else if (load_i) begin
      active_q   <= 1'b1;
      strobing_q <= 1'b1;
      slot_q     <= TOP_SLOT;
      cnt_q      <= '0;
    end else if (active_q) begin
      if (cnt_q == last) begin
        cnt_q <= '0;
        if (slot_q == '0) begin
          slot_q     <= TOP_SLOT;
          strobing_q <= 1'b0;
        end else begin
          slot_q <= slot_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign slot_o   = slot_q;
  assign cnt_o    = cnt_q;
  assign stb_o    = active_q & strobing_q & (cnt_q == STB_AT);
endmodule

// File: rtl/mdisp_blink.sv
`timescale 1ns/1ps
module mdisp_blink
  import mdisp_pkg::*;
#(
  parameter int BLINK_CYC = 2000,
  localparam int BW = $clog2(BLINK_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic ovr_i,
  input  logic active_i,
  output logic blank_o
);
  localparam logic [BW-1:0] B_LAST = BW'(BLINK_CYC - 1);

  logic [BW-1:0] bcnt_q;
  blink_ph_e     ph_q;
  logic          ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      ph_q   <= PH_SHOW;
      ovr_q  <= 1'b0;
    end else if (load_i) begin
      bcnt_q <= '0;
      ph_q   <= PH_SHOW;
      ovr_q  <= ovr_i;
    end else if (active_i) begin
      if (bcnt_q == B_LAST) begin
        bcnt_q <= '0;
        ph_q   <= (ph_q == PH_SHOW) ? PH_BLANK : PH_SHOW;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign blank_o = ovr_q & (ph_q == PH_BLANK);
endmodule

// File: rtl/mdisp_mux.sv
`timescale 1ns/1ps
module mdisp_mux #(
  parameter int NDIG = 5,
  parameter int DW   = 4,
  localparam int SW  = $clog2(NDIG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NDIG*DW-1:0] digits_i,
  input  logic               active_i,
  input  logic               blank_i,
  input  logic [SW-1:0]      slot_i,
  output logic [DW-1:0]      bcd_o,
  output logic [NDIG-1:0]    dig_o
);
  logic [NDIG-1:0][DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_i) begin
      for (int i = 0; i < NDIG; i++) data_q[i] <= digits_i[i*DW +: DW];
    end
  end

  assign bcd_o = active_i ? data_q[slot_i] : '0;
  assign dig_o = (active_i && !blank_i) ? (NDIG'(1) << slot_i) : '0;
endmodule

// File: rtl/mdisp_scan.sv
`timescale 1ns/1ps
module mdisp_scan #(
  parameter int NDIG      = 5,
  parameter int DW        = 4,
  parameter int MSD_LEN   = 201,
  parameter int DIG_LEN   = 200,
  parameter int STB_POS   = 100,
  parameter int BLINK_CYC = 2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cycle_end_i,
  input  logic [NDIG*DW-1:0] digits_i,
  input  logic               ovr_i,
  output logic [DW-1:0]      bcd_o,
  output logic [NDIG-1:0]    dig_o,
  output logic               strobe_n_o
);
  localparam int CW = $clog2(MSD_LEN + 1);
  localparam int SW = $clog2(NDIG);

  logic          active;
  logic [SW-1:0] slot_q;
  logic [CW-1:0] cnt_q;
  logic          stb;
  logic          blank;

  mdisp_timer #(
    .NDIG(NDIG), .MSD_LEN(MSD_LEN), .DIG_LEN(DIG_LEN), .STB_POS(STB_POS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(cycle_end_i),
    .active_o(active), .slot_o(slot_q), .cnt_o(cnt_q), .stb_o(stb)
  );

  mdisp_blink #(.BLINK_CYC(BLINK_CYC)) u_blink (
    .clk(clk), .rst_n(rst_n), .load_i(cycle_end_i), .ovr_i(ovr_i),
    .active_i(active), .blank_o(blank)
  );

  mdisp_mux #(.NDIG(NDIG), .DW(DW)) u_mux (
    .clk(clk), .rst_n(rst_n), .load_i(cycle_end_i), .digits_i(digits_i),
    .active_i(active), .blank_i(blank), .slot_i(slot_q),
    .bcd_o(bcd_o), .dig_o(dig_o)
  );

  // Strobe shows only in the low half of the cycle, after the decode has settled.
  assign strobe_n_o = ~(stb & ~clk);
endmodule

// File: rtl/mdisp_scan_chk.sv
`timescale 1ns/1ps
module mdisp_scan_chk #(
  parameter int NDIG = 5,
  parameter int DW   = 4,
  parameter int CW   = 8,
  parameter int SW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            load,
  input logic            active,
  input logic [SW-1:0]   slot,
  input logic [CW-1:0]   cnt,
  input logic            stb,
  input logic [DW-1:0]   bcd,
  input logic [NDIG-1:0] dig
);
  localparam int NW = $clog2(NDIG + 2);
  logic [NW-1:0] nstb_q;

  always_ff @(posedge clk) begin
    if (!rst_n || load) nstb_q <= '0;
    else if (stb && nstb_q != NW'(NDIG + 1)) nstb_q <= nstb_q + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (dig == '0 && !stb));
  p_msd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active && slot == SW'(NDIG - 1) && cnt == '0));
  p_one_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig));
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !load) |=> !stb);
  p_strobe_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (nstb_q < NW'(NDIG)));
  p_bcd_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(slot) && !$past(load)) |-> $stable(bcd));
endmodule

bind mdisp_scan mdisp_scan_chk #(.NDIG(NDIG), .DW(DW), .CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(cycle_end_i), .active(active),
  .slot(slot_q), .cnt(cnt_q), .stb(stb), .bcd(bcd_o), .dig(dig_o)
);

// File: tb/test_mdisp_scan.sv
`timescale 1ns/1ps
module test_mdisp_scan;
  localparam int BL    = 2000;
  localparam int FRAME = 1001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cycle_end = 1'b0;
  logic [19:0] digits = '0;
  logic        ovr = 1'b0;
  logic [3:0]  bcd;
  logic [4:0]  dig;
  logic        strobe_n;

  int checks = 0;
  int errors = 0;

  int          k = -1;
  logic [19:0] m_data = '0;
  logic        m_ovr = 1'b0;
  int          nstb = 0;

  always #2.5 clk = ~clk;

  mdisp_scan i_mdisp_scan (
    .clk(clk), .rst_n(rst_n), .cycle_end_i(cycle_end), .digits_i(digits),
    .ovr_i(ovr), .bcd_o(bcd), .dig_o(dig), .strobe_n_o(strobe_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s k=%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  // Reference model: cycles since the last capture.
  always @(posedge clk) begin
    if (!rst_n) k = -1;
    else if (cycle_end) begin
      k = 0; m_data = digits; m_ovr = ovr; nstb = 0;
    end else if (k >= 0) k++;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (k < 0) begin
        chk(dig == 5'd0 && bcd == 4'd0 && strobe_n == 1'b1, "R1 idle",
            {dig, bcd, strobe_n}, 10'h001);
      end else begin
        int p, idx, off;
        logic [4:0] edig;
        logic       estb, blank;
        p = k % FRAME;
        if (p < 201) begin idx = 4; off = p; end
        else begin idx = 3 - (p - 201) / 200; off = (p - 201) % 200; end
        blank = m_ovr && (((k / BL) % 2) == 1);
        edig  = blank ? 5'd0 : (5'd1 << idx);
        estb  = (k < FRAME) && (off == 100);
        if (!strobe_n) nstb++;
        chk(dig == edig, blank ? "R7 blank" : (p < 201 ? "R2 msd" : "R3 order"),
            dig, edig);
        chk(bcd == m_data[idx*4 +: 4], "R6 bcd", bcd, m_data[idx*4 +: 4]);
        chk(strobe_n == !estb, "R4 strobe", strobe_n, !estb);
      end
    end
  end

  task automatic load(input logic [19:0] d, input logic o);
    @(posedge clk); #0.5;
    digits = d; ovr = o; cycle_end = 1'b1;
    @(posedge clk); #0.5;
    cycle_end = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    run(5); #0.5 rst_n = 1'b1;
    run(20);                                   // R1 idle checks
    // R2/R3/R4/R6: plain capture
    load(20'h12345, 1'b0);
    run(600);
    #0.5 digits = 20'h99999; ovr = 1'b1;       // R8: no capture, no effect
    run(1500);
    chk(nstb == 5, "R5 strobe count", nstb, 5);
    // R7: overrange blinking across two blink periods
    load(20'h98760, 1'b1);
    run(4500);
    chk(nstb == 5, "R5 strobe count ovr", nstb, 5);
    // R8: restart in the middle of a walk
    load(20'h55501, 1'b0);
    run(450);
    load(20'h24680, 1'b0);
    @(negedge clk); #1.5;
    chk(dig == 5'b10000 && bcd == 4'h2, "R8 restart", {dig, bcd}, 9'h102);
    run(1100);
    chk(nstb == 5, "R8 fresh strobes", nstb, 5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule